// File: doc/BRIEF.md
# Hierarchical Interrupt Priority Encoder

This block gathers interrupt requests from three classes and folds them into one status word. Software reads that word to pick the source to service. The classes are critical (4 sources), main (17 sources) and peripheral (32 sources).

Each class has its own disable mask, in which a 1 turns a source off. For every class the word carries a pending flag and the index of the winning source. A cascaded sub-controller holds 32 sticky pending bits, cleared by writing ones, behind a mask of its own. Its summary takes the place of peripheral source 0.

A compact code output names the single source that software should handle first. The critical class ranks above main, and main ranks above peripheral. When the peripheral winner is the cascade, the code resolves down to the lowest enabled cascade bit. An interrupt line is raised whenever any class has an enabled request.

A single write port reaches all the configuration: the three class masks, the cascade mask and the cascade clear register. Per-source priority levels are fixed at zero. The critical source 2 and the main source 4, which a fuller system would use to forward peripheral requests, therefore behave like any other source of their class.

Top module: `irq_status_encoder`

## Requirements
- R1: After reset all class masks read as all-disabled and the cascade mask disables all 32 bits. No cascade bit is pending. `status_o`, `irq_code_o` and `irq_o` are 0 whatever the request inputs do.
- R2: The request inputs are registered on every clock edge. A change on any input or configuration write shows on the outputs after exactly one rising edge, never before it.
- R3: Fields of `status_o`:
  - Bit 10 is the critical flag, with the critical index in bits 9:8.
  - Bit 21 is the main flag, with the main index in bits 20:16.
  - Bit 29 is the peripheral flag, with the peripheral index in bits 28:24.
  - Every other bit is 0.
  - A class with nothing enabled and pending shows 0 in its flag and index.
- R4: Within a class, the lowest-numbered source that is both requesting and enabled wins.
- R5: The critical mask is written at `cfg_addr_i` = 0. Source n uses data bit 3-n, and a 1 disables it.
- R6: The main mask is written at address 1. Source n for n = 0 to 15 uses bit 15-n, and source 16 uses bit 16. A 1 disables the source.
- R7: The peripheral mask is written at address 2. Source n uses bit 31-n, and a 1 disables it. Peripheral source 0 is the cascade summary, which is 1 when any cascade bit is both pending and enabled. `per_req_i[k]` drives source k for k = 1 to 31.
- R8: A 1 on `sub_evt_i[n]` at a clock edge sets cascade pending bit n, and the bit stays set after the input falls. A write of data D at address 4 clears the pending bits where D has a 1 and leaves the others alone. A set and a clear of the same bit in one cycle leave the bit set.
- R9: The cascade mask is written at address 3. Bit n set to 1 keeps pending bit n out of the summary and the code, and the pending bit itself is kept.
- R10: `irq_code_o` = {class[2:0], index[4:0]}. The class values are:
  - 1: critical.
  - 2: main.
  - 3: peripheral with a nonzero index.
  - 4: cascade, when the peripheral winner is source 0; the index is then the lowest enabled pending cascade bit.
  - 0: nothing pending, in which case the whole code is 0.
  Critical ranks above main, and main ranks above peripheral.
- R11: `irq_o` is 1 exactly when at least one of the three class flags in `status_o` is 1.
- R12: A write takes effect only when `cfg_we_i` is 1. Addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| crit_req_i | input | 4 | Critical class requests, bit n is source n |
| main_req_i | input | 17 | Main class requests, bit n is source n |
| per_req_i | input | 31 (31:1) | Peripheral requests for sources 1 to 31 |
| sub_evt_i | input | 32 | Cascade set events, bit n sets pending bit n |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration target: 0 crit mask, 1 main mask, 2 periph mask, 3 cascade mask, 4 cascade clear |
| cfg_wdata_i | input | 32 | Configuration write data |
| status_o | output | 32 | Encoded class flags and indices |
| irq_code_o | output | 8 | Class and index of the single top source |
| irq_o | output | 1 | Interrupt request, any class pending |

## Verification
A wrong mask bit, pending bit or request register shows up at the ports one rising edge after it goes wrong. It appears either as a flag in `status_o`, a wrong winner index, or a class in `irq_code_o` that disagrees with the flags.

Cascade state can sit hidden behind its mask. The bench exposes it by unmasking afterwards and reading the resolved index, so a lost or spurious pending bit becomes visible one edge after the mask write.

Bit-reversed mask placement is covered by masking the lowest source of each class and watching the winning index move up by one.

// File: rtl/ise_pkg.sv
// Shared constants and types for the hierarchical interrupt status encoder.
// Assumes a 32-bit configuration data path and a fixed status word layout.
package ise_pkg;

    localparam int CFG_W  = 32;
    localparam int CFG_AW = 3;
    localparam int STAT_W = 32;

    // Status word field positions (software decodes these)
    localparam int CRIT_FLAG_BIT = 10;
    localparam int CRIT_IDX_LSB  = 8;
    localparam int CRIT_IDX_W    = 2;
    localparam int MAIN_FLAG_BIT = 21;
    localparam int MAIN_IDX_LSB  = 16;
    localparam int MAIN_IDX_W    = 5;
    localparam int PER_FLAG_BIT  = 29;
    localparam int PER_IDX_LSB   = 24;
    localparam int PER_IDX_W     = 5;

    localparam int CODE_IDX_W = 5;
    localparam int CODE_CLS_W = 3;
    localparam int CODE_W     = CODE_CLS_W + CODE_IDX_W;

    // Configuration targets
    localparam logic [CFG_AW-1:0] CFG_CRIT_MASK = 3'd0;
    localparam logic [CFG_AW-1:0] CFG_MAIN_MASK = 3'd1;
    localparam logic [CFG_AW-1:0] CFG_PER_MASK  = 3'd2;
    localparam logic [CFG_AW-1:0] CFG_SUB_MASK  = 3'd3;
    localparam logic [CFG_AW-1:0] CFG_SUB_CLEAR = 3'd4;

    typedef enum logic [CODE_CLS_W-1:0] {
        WIN_NONE    = 3'd0,
        WIN_CRIT    = 3'd1,
        WIN_MAIN    = 3'd2,
        WIN_PERIPH  = 3'd3,
        WIN_CASCADE = 3'd4
    } win_class_e;

    // Data bit that holds the mask of source src: reversed up to rev_top, direct above it
    function automatic int mask_pos(int src, int rev_top);
        return (src <= rev_top) ? (rev_top - src) : src;
    endfunction

    // All data bits that belong to a class of n sources
    function automatic logic [CFG_W-1:0] class_bits(int n, int rev_top);
        logic [CFG_W-1:0] m;
        m = '0;
        for (int s = 0; s < n; s++) m[mask_pos(s, rev_top)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ise_first_set.sv
// Lowest-index finder: reports whether any bit of vec_i is set and the
// index of the lowest set bit (0 when none). Purely combinational.
module ise_first_set #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    // Scan from the top so the lowest set bit is the last to assign
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end

endmodule

// File: rtl/ise_class_lane.sv
// One request class: holds the disable mask (stored per source, written from
// bit-reversed data positions) and picks the lowest enabled pending source.
// Assumes req_i is already registered by the caller.
module ise_class_lane
    import ise_pkg::*;
#(
    parameter int N       = 4,
    parameter int REV_TOP = 3,
    parameter int IW      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic             mask_we_i,
    input  logic [CFG_W-1:0] mask_wdata_i,
    output logic             hit_o,
    output logic [IW-1:0]    idx_o
);

    localparam logic [CFG_W-1:0] OWN_BITS = class_bits(N, REV_TOP);

    logic [N-1:0] mask_q;
    logic [N-1:0] live;
    logic         unused_wbits;

    // Data bits outside this class carry no state
    assign unused_wbits = ^(mask_wdata_i & ~OWN_BITS);

    // Mask register: reset disables all, writes pick each source's reversed bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we_i) begin
            for (int s = 0; s < N; s++) mask_q[s] <= mask_wdata_i[mask_pos(s, REV_TOP)];
        end
    end

    // Per-source gating of requests by the mask
    for (genvar g = 0; g < N; g++) begin : g_gate
        assign live[g] = req_i[g] & ~mask_q[g];
    end

    ise_first_set #(.N(N), .IW(IW)) u_pick (
        .vec_i (live),
        .any_o (hit_o),
        .idx_o (idx_o)
    );

endmodule

// File: rtl/ise_cascade.sv
// Cascaded sub-controller: sticky pending bits set by events and cleared by
// write-one-to-clear, a mask of its own, a summary and the lowest enabled bit.
// A set and a clear of one bit in the same cycle leave it set.
module ise_cascade
    import ise_pkg::*;
#(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     evt_i,
    input  logic             clr_we_i,
    input  logic             mask_we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [N-1:0]     pend_o,
    output logic             sum_o,
    output logic [IW-1:0]    idx_o
);

    logic [N-1:0] pend_q;
    logic [N-1:0] smask_q;
    logic [N-1:0] clr_bits;

    assign clr_bits = clr_we_i ? wdata_i[N-1:0] : '0;

    // Pending bits: clear by ones first, then events set (set wins)
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_bits) | evt_i;
    end

    // Cascade mask: reset disables all bits
    always_ff @(posedge clk) begin
        if (!rst_n)         smask_q <= '1;
        else if (mask_we_i) smask_q <= wdata_i[N-1:0];
    end

    assign pend_o = pend_q;

    ise_first_set #(.N(N), .IW(IW)) u_pick (
        .vec_i (pend_q & ~smask_q),
        .any_o (sum_o),
        .idx_o (idx_o)
    );

endmodule

// File: rtl/irq_status_encoder.sv
// Hierarchical interrupt status encoder top. Registers the request inputs,
// keeps three class lanes and the cascade, and forms the status word, the
// single-winner code and the interrupt line. Outputs are combinational from
// registered state, so every change appears one clock edge later.
module irq_status_encoder
    import ise_pkg::*;
#(
    parameter int CRIT_N   = 4,
    parameter int MAIN_N   = 17,
    parameter int PER_N    = 32,
    parameter int SUB_N    = 32,
    parameter int CRIT_REV = 3,
    parameter int MAIN_REV = 15,
    parameter int PER_REV  = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CRIT_N-1:0]    crit_req_i,
    input  logic [MAIN_N-1:0]    main_req_i,
    input  logic [PER_N-1:1]     per_req_i,
    input  logic [SUB_N-1:0]     sub_evt_i,
    input  logic                 cfg_we_i,
    input  logic [CFG_AW-1:0]    cfg_addr_i,
    input  logic [CFG_W-1:0]     cfg_wdata_i,
    output logic [STAT_W-1:0]    status_o,
    output logic [CODE_W-1:0]    irq_code_o,
    output logic                 irq_o
);

    localparam int CRIT_IW = $clog2(CRIT_N);
    localparam int MAIN_IW = $clog2(MAIN_N);
    localparam int PER_IW  = $clog2(PER_N);
    localparam int SUB_IW  = $clog2(SUB_N);

    logic [CRIT_N-1:0] crit_q;
    logic [MAIN_N-1:0] main_q;
    logic [PER_N-1:1]  per_q;

    logic               crit_hit, main_hit, per_hit, sub_sum;
    logic [CRIT_IW-1:0] crit_idx;
    logic [MAIN_IW-1:0] main_idx;
    logic [PER_IW-1:0]  per_idx;
    logic [SUB_IW-1:0]  sub_idx;
    logic [SUB_N-1:0]   sub_pend;

    win_class_e             win_cls;
    logic [CODE_IDX_W-1:0]  win_idx;

    // Request capture: one register stage for all external requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crit_q <= '0;
            main_q <= '0;
            per_q  <= '0;
        end else begin
            crit_q <= crit_req_i;
            main_q <= main_req_i;
            per_q  <= per_req_i;
        end
    end

    ise_class_lane #(.N(CRIT_N), .REV_TOP(CRIT_REV), .IW(CRIT_IW)) u_crit (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (crit_q),
        .mask_we_i    (cfg_we_i && cfg_addr_i == CFG_CRIT_MASK),
        .mask_wdata_i (cfg_wdata_i),
        .hit_o        (crit_hit),
        .idx_o        (crit_idx)
    );

    ise_class_lane #(.N(MAIN_N), .REV_TOP(MAIN_REV), .IW(MAIN_IW)) u_main (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (main_q),
        .mask_we_i    (cfg_we_i && cfg_addr_i == CFG_MAIN_MASK),
        .mask_wdata_i (cfg_wdata_i),
        .hit_o        (main_hit),
        .idx_o        (main_idx)
    );

    ise_class_lane #(.N(PER_N), .REV_TOP(PER_REV), .IW(PER_IW)) u_per (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        ({per_q, sub_sum}),
        .mask_we_i    (cfg_we_i && cfg_addr_i == CFG_PER_MASK),
        .mask_wdata_i (cfg_wdata_i),
        .hit_o        (per_hit),
        .idx_o        (per_idx)
    );

    ise_cascade #(.N(SUB_N), .IW(SUB_IW)) u_cascade (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (sub_evt_i),
        .clr_we_i  (cfg_we_i && cfg_addr_i == CFG_SUB_CLEAR),
        .mask_we_i (cfg_we_i && cfg_addr_i == CFG_SUB_MASK),
        .wdata_i   (cfg_wdata_i),
        .pend_o    (sub_pend),
        .sum_o     (sub_sum),
        .idx_o     (sub_idx)
    );

    // Status word assembly: each class fills only its own fields
    always_comb begin
        status_o = '0;
        status_o[CRIT_FLAG_BIT] = crit_hit;
        status_o[MAIN_FLAG_BIT] = main_hit;
        status_o[PER_FLAG_BIT]  = per_hit;
        status_o[CRIT_IDX_LSB +: CRIT_IDX_W] = crit_hit ? CRIT_IDX_W'(crit_idx) : '0;
        status_o[MAIN_IDX_LSB +: MAIN_IDX_W] = main_hit ? MAIN_IDX_W'(main_idx) : '0;
        status_o[PER_IDX_LSB  +: PER_IDX_W]  = per_hit  ? PER_IDX_W'(per_idx)   : '0;
    end

    // Single winner: fixed class rank, cascade resolved behind peripheral 0
    always_comb begin
        win_cls = WIN_NONE;
        win_idx = '0;
        if (crit_hit) begin
            win_cls = WIN_CRIT;
            win_idx = CODE_IDX_W'(crit_idx);
        end else if (main_hit) begin
            win_cls = WIN_MAIN;
            win_idx = CODE_IDX_W'(main_idx);
        end else if (per_hit) begin
            if (per_idx == '0) begin
                win_cls = WIN_CASCADE;
                win_idx = CODE_IDX_W'(sub_idx);
            end else begin
                win_cls = WIN_PERIPH;
                win_idx = CODE_IDX_W'(per_idx);
            end
        end
    end

    assign irq_code_o = {win_cls, win_idx};

    // Interrupt line: any class with an enabled request
    assign irq_o = crit_hit | main_hit | per_hit;

endmodule

// File: rtl/irq_status_encoder_checker.sv
// Property checker for the status encoder, attached to every instance by bind.
// Observes the outputs, the event inputs and the cascade pending vector.
module irq_status_encoder_checker
    import ise_pkg::*;
#(
    parameter int SUB_N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] status,
    input logic [CODE_W-1:0] code,
    input logic              irq,
    input logic [SUB_N-1:0]  sub_evt,
    input logic [SUB_N-1:0]  sub_pend
);

    localparam logic [STAT_W-1:0] FIELD_BITS =
        (STAT_W'(1) << CRIT_FLAG_BIT) | (STAT_W'(3) << CRIT_IDX_LSB) |
        (STAT_W'(1) << MAIN_FLAG_BIT) | (STAT_W'(31) << MAIN_IDX_LSB) |
        (STAT_W'(1) << PER_FLAG_BIT)  | (STAT_W'(31) << PER_IDX_LSB);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (status == '0 && code == '0 && !irq)); // R1

    AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~FIELD_BITS) == '0); // R3

    AST_IDLE_CRIT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        !status[CRIT_FLAG_BIT] |-> status[CRIT_IDX_LSB +: CRIT_IDX_W] == '0); // R3

    AST_CLASS_RANK_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
        status[CRIT_FLAG_BIT] |-> (code[CODE_W-1 -: CODE_CLS_W] == WIN_CRIT &&
                                   code[CODE_IDX_W-1:0] == CODE_IDX_W'(status[CRIT_IDX_LSB +: CRIT_IDX_W]))); // R10

    AST_CLASS_RANK_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[CRIT_FLAG_BIT] && status[MAIN_FLAG_BIT]) |->
            code[CODE_W-1 -: CODE_CLS_W] == WIN_MAIN); // R10

    AST_CASCADE_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[CRIT_FLAG_BIT] && !status[MAIN_FLAG_BIT] && status[PER_FLAG_BIT] &&
         status[PER_IDX_LSB +: PER_IDX_W] == '0) |->
            code[CODE_W-1 -: CODE_CLS_W] == WIN_CASCADE); // R10

    AST_IRQ_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (code != '0)); // R11

    AST_EVENT_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((sub_pend & $past(sub_evt)) == $past(sub_evt))); // R8

endmodule

bind irq_status_encoder irq_status_encoder_checker #(.SUB_N(SUB_N)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .status   (status_o),
    .code     (irq_code_o),
    .irq      (irq_o),
    .sub_evt  (sub_evt_i),
    .sub_pend (sub_pend)
);

// File: tb/irq_status_encoder_test.sv
// Bench for the status encoder: a vector table of class request patterns,
// then directed tests for reset, latency, mask bit order, cascade and decode.
module irq_status_encoder_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  crit_req;
    logic [16:0] main_req;
    logic [31:0] per_req;
    logic [31:0] sub_evt;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] status;
    logic [7:0]  code;
    logic        irq;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    irq_status_encoder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .crit_req_i  (crit_req),
        .main_req_i  (main_req),
        .per_req_i   (per_req[31:1]),
        .sub_evt_i   (sub_evt),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .status_o    (status),
        .irq_code_o  (code),
        .irq_o       (irq)
    );

    // {crit[3:0], main[16:0], per[31:0], exp_status[31:0], exp_code[7:0]}
    localparam int NV = 7;
    localparam logic [92:0] VEC [NV] = '{
        {4'h0, 17'h00000, 32'h0000_0000, 32'h0000_0000, 8'h00},
        {4'hC, 17'h00010, 32'h8000_0000, 32'h3F24_0600, 8'h22},
        {4'h0, 17'h10100, 32'h0000_0006, 32'h2128_0000, 8'h48},
        {4'h0, 17'h00000, 32'h0010_0000, 32'h3400_0000, 8'h74},
        {4'h1, 17'h00000, 32'h0000_0000, 32'h0000_0400, 8'h20},
        {4'h0, 17'h10000, 32'h0000_0000, 32'h0030_0000, 8'h50},
        {4'h8, 17'h00000, 32'h0000_0000, 32'h0000_0700, 8'h23}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    endtask

    task automatic apply(input logic [3:0] c, input logic [16:0] m, input logic [31:0] p);
        @(negedge clk);
        crit_req = c; main_req = m; per_req = p;
        @(negedge clk);
    endtask

    task automatic pulse_evt(input logic [31:0] e);
        @(negedge clk);
        sub_evt = e;
        @(negedge clk);
        sub_evt = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        crit_req = '1; main_req = '1; per_req = '1; sub_evt = '1;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sub_evt = '0;
        @(negedge clk);
        // R1: all masks disable after reset, requests held high
        check("R1 status after reset", status, 32'h0);
        check("R1 code after reset", {24'h0, code}, 32'h0);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);

        // R5: open critical mask, all four requesting -> source 0
        cfg_write(3'd0, 32'h0);
        check("R5 crit unmasked", status, 32'h0000_0400);

        // R2: new request not visible before the edge, visible after it
        @(negedge clk);
        crit_req = 4'b0100;
        #1;
        check("R2 before edge", status, 32'h0000_0400);
        @(negedge clk);
        check("R2 after one edge", status, 32'h0000_0600);

        cfg_write(3'd1, 32'h0);
        cfg_write(3'd2, 32'h0);

        // R3 R4 R10 R11: vector table, all class masks open, cascade masked
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][92:89], VEC[v][88:72], VEC[v][71:40]);
            check($sformatf("R3 R4 status vec %0d", v), status, VEC[v][39:8]);
            check($sformatf("R10 code vec %0d", v), {24'h0, code}, {24'h0, VEC[v][7:0]});
            check($sformatf("R11 irq vec %0d", v), {31'h0, irq}, {31'h0, (VEC[v][39:8] != 0)});
        end

        // R5: bit 3 disables critical source 0
        apply(4'b0011, '0, '0);
        cfg_write(3'd0, 32'h0000_0008);
        check("R5 crit src0 masked", status, 32'h0000_0500);
        cfg_write(3'd0, 32'h0);

        // R6: bit 15 disables main source 0, bit 16 disables source 16
        apply('0, 17'h00003, '0);
        cfg_write(3'd1, 32'h0000_8000);
        check("R6 main src0 masked", status, 32'h0021_0000);
        apply('0, 17'h10000, '0);
        cfg_write(3'd1, 32'h0001_0000);
        check("R6 main src16 masked", status, 32'h0);
        cfg_write(3'd1, 32'h0);

        // R7: bit 30 disables peripheral source 1
        apply('0, '0, 32'h0000_0006);
        cfg_write(3'd2, 32'h4000_0000);
        check("R7 per src1 masked", status, 32'h2200_0000);
        cfg_write(3'd2, 32'h0);

        // R12: unused address and a write without strobe change nothing
        apply('0, '0, 32'h0000_0002);
        cfg_write(3'd5, 32'hFFFF_FFFF);
        check("R12 addr 5 ignored", status, 32'h2100_0000);
        @(negedge clk);
        cfg_addr = 3'd2; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cfg_addr = '0; cfg_wdata = '0;
        check("R12 no strobe ignored", status, 32'h2100_0000);
        apply('0, '0, '0);

        // R9: pending bit set while masked stays hidden, then appears
        pulse_evt(32'h0000_0020);
        check("R9 masked pending hidden", status, 32'h0);
        cfg_write(3'd3, 32'h0);
        check("R8 R9 sticky bit 5 status", status, 32'h2000_0000);
        check("R10 cascade code bit 5", {24'h0, code}, 32'h85);
        check("R11 irq from cascade", {31'h0, irq}, 32'h1);

        // R8: lowest bit wins, clear by one, zero leaves alone
        pulse_evt(32'h0000_0200);
        check("R8 lowest cascade bit", {24'h0, code}, 32'h85);
        cfg_write(3'd4, 32'h0000_0020);
        check("R8 clear bit 5", {24'h0, code}, 32'h89);
        cfg_write(3'd4, 32'h0);
        check("R8 zero write keeps", {24'h0, code}, 32'h89);

        // R8: set and clear of bit 7 together leaves it set
        @(negedge clk);
        sub_evt = 32'h0000_0080;
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 32'h0000_0080;
        @(negedge clk);
        sub_evt = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        check("R8 set beats clear", {24'h0, code}, 32'h87);

        // R9: masking bit 7 hides it but keeps it pending
        cfg_write(3'd3, 32'h0000_0080);
        check("R9 bit 7 masked", {24'h0, code}, 32'h89);
        cfg_write(3'd3, 32'h0);
        check("R9 bit 7 retained", {24'h0, code}, 32'h87);

        cfg_write(3'd4, 32'hFFFF_FFFF);
        check("R8 clear all status", status, 32'h0);
        check("R11 irq low when idle", {31'h0, irq}, 32'h0);

        // R7 R10: cascade as source 0 beats peripheral source 3
        pulse_evt(32'h0000_0004);
        apply('0, '0, 32'h0000_0008);
        check("R7 cascade wins periph", status, 32'h2000_0000);
        check("R10 cascade code bit 2", {24'h0, code}, 32'h82);

        done = 1'b1;
        finish_run();
    end

endmodule